// File: doc/BRIEF.md
# Per-Area External Bus Access Sequencer

This block runs the external bus cycles of a small microcontroller's bus controller. The external address space is split into eight areas. The top address bits of a request pick the area. Each area carries its own settings: a width bit (8- or 16-bit data path), a state bit (2- or 3-state basic cycle) and a 2-bit programmed wait count. The wait count is honoured only by 3-state areas.

A CPU-side request carries an address, a word/byte size flag, a read/write flag and write data. The sequencer is offered the request only for external areas; on-chip memory and internal registers have fixed timing and never reach it. From the request it produces the external address, a read strobe, separate write strobes for the upper and lower byte lanes, and the write data on a 16-bit bus. When the access ends it pulses done and presents the read data. A word transfer to an 8-bit area becomes two byte cycles. A status output reports whether the bus as a whole runs in 16-bit mode.

Top module: `ebs_sequencer`

## Requirements
- R1: The area is the top three bits of `req_addr`; area n uses `cfg_width[n]`, `cfg_states[n]` and `cfg_waits[2n+1:2n]`. During a cycle, `ext_addr` equals the request address, with bit 0 set as R6 and R7 give.
- R2: With `cfg_states[n]`=0 every bus cycle lasts exactly 2 clocks (address state, then strobe state), whatever the wait field holds.
- R3: With `cfg_states[n]`=1 every bus cycle lasts 3+W clocks, W being the 2-bit wait field; the W waits sit between the second and the last state.
- R4: `ext_rd` is high for reads from the second state to the last state of each bus cycle. The write strobes are high for writes in the second state and the wait states only, and so are low in the last state of a 3-state cycle. No strobe is active in the address state.
- R5: In an 8-bit area (`cfg_width[n]`=0) data uses only the upper lane `[15:8]` and only `ext_wr_hi` is driven. A byte read returns the upper-lane byte in `req_rdata[7:0]` with `[15:8]` zero.
- R6: A word request (`req_word`=1) to an 8-bit area runs two bus cycles: the even address first, carrying `req_wdata[15:8]`, and then the odd address, carrying `req_wdata[7:0]`. Read data gathers as {first byte, second byte}. Done follows only the second cycle.
- R7: In a 16-bit area, a word uses the even address, both write strobes and the full bus, with `req_rdata`=`ext_din`. A byte at an even address uses the upper lane and `ext_wr_hi`; a byte at an odd address uses the lower lane and `ext_wr_lo`. The byte read lands in `req_rdata[7:0]` with `[15:8]` zero.
- R8: `bus16_mode` is 0 only when every `cfg_width` bit is 0.
- R9: A request is taken only while `req_ready` is high, which is only when the sequencer is idle. `req_valid` while busy starts no later access.
- R10: Changes to the configuration inputs during an access do not alter its timing, lanes or addresses.
- R11: `req_done` is a one-clock pulse in the clock after the last state, with `req_rdata` valid for reads. After reset the block is idle: `req_ready`=1, with done and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 24 | Request byte address |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte transfers use [7:0]) |
| req_done | output | 1 | Access complete pulse |
| req_rdata | output | 16 | Read data, valid with done |
| cfg_width | input | 8 | Per-area width, 1 = 16-bit |
| cfg_states | input | 8 | Per-area state count, 1 = 3-state |
| cfg_waits | input | 16 | Per-area 2-bit wait count |
| bus16_mode | output | 1 | 1 when any area is 16-bit |
| ext_addr | output | 24 | External address |
| ext_rd | output | 1 | Read strobe, active high |
| ext_wr_hi | output | 1 | Upper-lane write strobe, active high |
| ext_wr_lo | output | 1 | Lower-lane write strobe, active high |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
A wrong state register or wait counter shows first as a strobe pattern that is shifted or stretched. This appears at the ports in the clock where the error occurs, because every clock of every access is compared with the expected strobe pattern. A wrong width snapshot or split phase shows in the same clock as a wrong `ext_addr` bit 0 or a wrong lane. A read capture fault is seen in `req_rdata` when done pulses. A lost or extra phase moves done by whole bus cycles. The configuration is scrambled during every access, so a snapshot that is not held is caught in that same access.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3
    } seq_state_t;

    typedef struct packed {
        logic       wide;
        logic       three;
        logic [1:0] waits;
    } area_cfg_t;

    function automatic logic [3:0] phase_cycles(input area_cfg_t c);
        return c.three ? (4'd3 + {2'b00, c.waits}) : 4'd2;
    endfunction

endpackage

// File: rtl/ebs_area_decode.sv
module ebs_area_decode
    import ebs_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    localparam int AREA_W = $clog2(NUM_AREAS)
) (
    input  logic [AREA_W-1:0]      area,
    input  logic [NUM_AREAS-1:0]   cfg_width,
    input  logic [NUM_AREAS-1:0]   cfg_states,
    input  logic [2*NUM_AREAS-1:0] cfg_waits,
    output area_cfg_t              sel,
    output logic                   bus16
);

    area_cfg_t cfg_tab [NUM_AREAS];

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        assign cfg_tab[g] = '{wide: cfg_width[g], three: cfg_states[g], waits: cfg_waits[2*g +: 2]};
    end

    assign sel   = cfg_tab[area];
    assign bus16 = |cfg_width;

endmodule

// File: rtl/ebs_lane_steer.sv
module ebs_lane_steer
    import ebs_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int BYTE_W = DATA_W / 2
) (
    input  area_cfg_t          cfg,
    input  logic               word,
    input  logic               phase,
    input  logic               addr0_req,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  din,
    input  logic [BYTE_W-1:0]  rdata_hi_cur,
    output logic               lane_hi,
    output logic               lane_lo,
    output logic               addr0_bus,
    output logic [DATA_W-1:0]  dout,
    output logic [DATA_W-1:0]  rdata_next
);

    logic [BYTE_W-1:0] narrow_byte;
    logic [BYTE_W-1:0] din_hi;
    logic [BYTE_W-1:0] din_lo;

    assign din_hi      = din[DATA_W-1:BYTE_W];
    assign din_lo      = din[BYTE_W-1:0];
    assign narrow_byte = (word && !phase) ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];

    always_comb begin
        if (!cfg.wide) begin
            lane_hi    = 1'b1;
            lane_lo    = 1'b0;
            addr0_bus  = word ? phase : addr0_req;
            dout       = {narrow_byte, {BYTE_W{1'b0}}};
            if (!word)
                rdata_next = {{BYTE_W{1'b0}}, din_hi};
            else if (!phase)
                rdata_next = {din_hi, {BYTE_W{1'b0}}};
            else
                rdata_next = {rdata_hi_cur, din_hi};
        end else if (word) begin
            lane_hi    = 1'b1;
            lane_lo    = 1'b1;
            addr0_bus  = 1'b0;
            dout       = wdata;
            rdata_next = din;
        end else begin
            lane_hi    = !addr0_req;
            lane_lo    = addr0_req;
            addr0_bus  = addr0_req;
            dout       = addr0_req ? {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]}
                                   : {wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
            rdata_next = {{BYTE_W{1'b0}}, addr0_req ? din_lo : din_hi};
        end
    end

endmodule

// File: rtl/ebs_sequencer.sv
module ebs_sequencer
    import ebs_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    localparam int AREA_W   = $clog2(NUM_AREAS),
    localparam int BYTE_W   = DATA_W / 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_word,
    input  logic                   req_write,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_done,
    output logic [DATA_W-1:0]      req_rdata,
    input  logic [NUM_AREAS-1:0]   cfg_width,
    input  logic [NUM_AREAS-1:0]   cfg_states,
    input  logic [2*NUM_AREAS-1:0] cfg_waits,
    output logic                   bus16_mode,
    output logic [ADDR_W-1:0]      ext_addr,
    output logic                   ext_rd,
    output logic                   ext_wr_hi,
    output logic                   ext_wr_lo,
    output logic [DATA_W-1:0]      ext_dout,
    input  logic [DATA_W-1:0]      ext_din
);

    seq_state_t        st;
    area_cfg_t         dec_cfg;
    area_cfg_t         cur_cfg;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_word;
    logic              cur_write;
    logic [DATA_W-1:0] cur_wdata;
    logic              phase;
    logic [1:0]        wait_left;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    logic              split;
    logic              last_state;
    logic              rd_span;
    logic              wr_span;
    logic              lane_hi;
    logic              lane_lo;
    logic              addr0_bus;
    logic [DATA_W-1:0] lane_dout;
    logic [DATA_W-1:0] rdata_next;

    ebs_area_decode #(.NUM_AREAS(NUM_AREAS)) u_decode (
        .area       (req_addr[ADDR_W-1 -: AREA_W]),
        .cfg_width  (cfg_width),
        .cfg_states (cfg_states),
        .cfg_waits  (cfg_waits),
        .sel        (dec_cfg),
        .bus16      (bus16_mode)
    );

    ebs_lane_steer #(.DATA_W(DATA_W)) u_lanes (
        .cfg          (cur_cfg),
        .word         (cur_word),
        .phase        (phase),
        .addr0_req    (cur_addr[0]),
        .wdata        (cur_wdata),
        .din          (ext_din),
        .rdata_hi_cur (rdata_q[DATA_W-1:BYTE_W]),
        .lane_hi      (lane_hi),
        .lane_lo      (lane_lo),
        .addr0_bus    (addr0_bus),
        .dout         (lane_dout),
        .rdata_next   (rdata_next)
    );

    assign split      = cur_word && !cur_cfg.wide;
    assign last_state = (st == ST_T3) || (st == ST_T2 && !cur_cfg.three);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cur_cfg   <= '0;
            cur_addr  <= '0;
            cur_word  <= 1'b0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
            phase     <= 1'b0;
            wait_left <= 2'd0;
            done_q    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        st        <= ST_T1;
                        cur_cfg   <= dec_cfg;
                        cur_addr  <= req_addr;
                        cur_word  <= req_word;
                        cur_write <= req_write;
                        cur_wdata <= req_wdata;
                        phase     <= 1'b0;
                    end
                end
                ST_T1: begin
                    st        <= ST_T2;
                    wait_left <= cur_cfg.waits;
                end
                ST_T2: begin
                    st <= (wait_left != 2'd0) ? ST_TW : ST_T3;
                end
                ST_TW: begin
                    if (wait_left == 2'd1)
                        st <= ST_T3;
                    wait_left <= wait_left - 2'd1;
                end
                default: ;
            endcase
            if (last_state) begin
                if (!cur_write)
                    rdata_q <= rdata_next;
                if (split && !phase) begin
                    phase <= 1'b1;
                    st    <= ST_T1;
                end else begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign rd_span   = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
    assign wr_span   = (st == ST_T2) || (st == ST_TW);

    assign req_ready = (st == ST_IDLE);
    assign req_done  = done_q;
    assign req_rdata = rdata_q;
    assign ext_addr  = (st == ST_IDLE) ? '0 : {cur_addr[ADDR_W-1:1], addr0_bus};
    assign ext_rd    = rd_span && !cur_write;
    assign ext_wr_hi = wr_span && cur_write && lane_hi;
    assign ext_wr_lo = wr_span && cur_write && lane_lo;
    assign ext_dout  = (st != ST_IDLE && cur_write) ? lane_dout : '0;

    logic [3:0] phase_cnt;
    always_ff @(posedge clk) begin
        if (rst || st == ST_IDLE || last_state)
            phase_cnt <= 4'd0;
        else
            phase_cnt <= phase_cnt + 4'd1;
    end

    // R2 R3
    phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        last_state |-> (phase_cnt == phase_cycles(cur_cfg) - 4'd1));

    // R2
    two_state_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !cur_cfg.three) |-> (st != ST_TW));

    // R4
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T3) |-> !(ext_wr_hi || ext_wr_lo));

    // R4
    addr_state_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T1) |-> !(ext_rd || ext_wr_hi || ext_wr_lo));

    // R5
    narrow_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !cur_cfg.wide) |-> !ext_wr_lo);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(cur_addr));

    // R10
    cfg_snapshot_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_T1) |-> $stable(cur_cfg));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

endmodule

// File: tb/tb_ebs_sequencer.sv
module tb_ebs_sequencer;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [23:0] req_addr;
    logic        req_word;
    logic        req_write;
    logic [15:0] req_wdata;
    logic        req_done;
    logic [15:0] req_rdata;
    logic [7:0]  cfg_width;
    logic [7:0]  cfg_states;
    logic [15:0] cfg_waits;
    logic        bus16_mode;
    logic [23:0] ext_addr;
    logic        ext_rd;
    logic        ext_wr_hi;
    logic        ext_wr_lo;
    logic [15:0] ext_dout;
    logic [15:0] ext_din;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_wide = 1'b1;

    always #10 clk = !clk;

    ebs_sequencer dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata),
        .cfg_width(cfg_width), .cfg_states(cfg_states), .cfg_waits(cfg_waits),
        .bus16_mode(bus16_mode), .ext_addr(ext_addr), .ext_rd(ext_rd),
        .ext_wr_hi(ext_wr_hi), .ext_wr_lo(ext_wr_lo), .ext_dout(ext_dout),
        .ext_din(ext_din)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return (a[7:0] * 8'd29) ^ {5'b0, a[23:21]} ^ a[15:8];
    endfunction

    always_comb begin
        if (exp_wide)
            ext_din = {mem_byte({ext_addr[23:1], 1'b0}), mem_byte({ext_addr[23:1], 1'b1})};
        else
            ext_din = {mem_byte(ext_addr), ~mem_byte(ext_addr)};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_access(input logic [2:0] ar, input logic word, input logic wr,
                              input logic a0, input logic [19:0] mid,
                              input logic [15:0] wd, input bit poke);
        logic        w16;
        logic        thr;
        logic [1:0]  ws;
        logic [23:0] adr;
        logic [7:0]  sv_w;
        logic [7:0]  sv_s;
        logic [15:0] sv_t;
        logic [15:0] exp_rd;
        int L;
        int P;
        int N;
        w16 = cfg_width[ar];
        thr = cfg_states[ar];
        ws  = cfg_waits[2*ar +: 2];
        L   = thr ? 3 + int'(ws) : 2;
        P   = (word && !w16) ? 2 : 1;
        N   = P * L;
        adr = {ar, mid, a0};
        @(negedge clk);
        exp_wide  = w16;
        req_valid = 1'b1;
        req_addr  = adr;
        req_word  = word;
        req_write = wr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        sv_w = cfg_width;
        sv_s = cfg_states;
        sv_t = cfg_waits;
        // R10: scramble the configuration while the access runs
        cfg_width  = ~sv_w;
        cfg_states = ~sv_s;
        cfg_waits  = ~sv_t;
        for (int j = 1; j <= N + 1; j++) begin
            if (j > 1) @(negedge clk);
            if (poke && j == 1) begin
                req_valid = 1'b1;
                req_addr  = {ar, 20'h0F0F0, 1'b0};
                req_write = 1'b1;
                chk(req_ready == 1'b0, "R9 ready low while busy", 32'(req_ready), 32'd0);
            end
            if (poke && j == N - 1) req_valid = 1'b0;
            if (j <= N) begin
                int ph;
                int o;
                logic act_wr;
                logic e_hi;
                logic e_lo;
                logic e_a0;
                logic [15:0] e_dout;
                logic [7:0]  nb;
                ph = (j - 1) / L;
                o  = (j - 1) % L;
                act_wr = wr && (o >= 1) && (!thr || o < L - 1);
                if (!w16) begin
                    e_hi = act_wr; e_lo = 1'b0;
                    e_a0 = word ? (ph == 1) : a0;
                    nb = (word && ph == 0) ? wd[15:8] : wd[7:0];
                    e_dout = {nb, 8'h00};
                end else if (word) begin
                    e_hi = act_wr; e_lo = act_wr; e_a0 = 1'b0; e_dout = wd;
                end else begin
                    e_hi = act_wr && !a0; e_lo = act_wr && a0; e_a0 = a0;
                    e_dout = a0 ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
                end
                chk({ext_rd, ext_wr_hi, ext_wr_lo} == {!wr && o >= 1, e_hi, e_lo},
                    thr ? "R4 R3 R5 R7 R10 strobes" : "R4 R2 R5 R7 R10 strobes",
                    32'({ext_rd, ext_wr_hi, ext_wr_lo}), 32'({!wr && o >= 1, e_hi, e_lo}));
                chk(ext_addr == {adr[23:1], e_a0}, "R1 R6 R7 address",
                    32'(ext_addr), 32'({adr[23:1], e_a0}));
                if (act_wr)
                    chk(ext_dout == e_dout, "R5 R6 R7 write data", 32'(ext_dout), 32'(e_dout));
                chk(req_done == 1'b0, "R6 R11 done early", 32'(req_done), 32'd0);
            end else begin
                chk(req_done == 1'b1, thr ? "R3 R6 R10 done timing" : "R2 R6 R10 done timing",
                    32'(req_done), 32'd1);
                if (!wr) begin
                    if (word)
                        exp_rd = {mem_byte({adr[23:1], 1'b0}), mem_byte({adr[23:1], 1'b1})};
                    else
                        exp_rd = {8'h00, mem_byte(adr)};
                    chk(req_rdata == exp_rd, "R5 R6 R7 R11 read data", 32'(req_rdata), 32'(exp_rd));
                end
            end
        end
        cfg_width  = sv_w;
        cfg_states = sv_s;
        cfg_waits  = sv_t;
        @(negedge clk);
        chk(req_done == 1'b0 && req_ready == 1'b1, "R11 single done pulse",
            32'({req_done, req_ready}), 32'b01);
    endtask

    task automatic set_cfg(input int c);
        for (int k = 0; k < 8; k++) begin
            logic [3:0] code;
            code = 4'((c + k * 5) % 16);
            cfg_width[k]        = code[3];
            cfg_states[k]       = code[2];
            cfg_waits[2*k +: 2] = code[1:0];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        req_word = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
        cfg_width = '0;
        cfg_states = '0;
        cfg_waits = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(req_ready && !req_done && !ext_rd && !ext_wr_hi && !ext_wr_lo,
            "R11 reset idle", 32'({req_ready, req_done, ext_rd, ext_wr_hi, ext_wr_lo}), 32'b10000);

        // R8 bus mode over all-narrow and each single wide area
        for (int b = -1; b < 8; b++) begin
            cfg_width = (b < 0) ? 8'h00 : (8'h01 << b);
            #1;
            chk(bus16_mode == (b >= 0), "R8 bus mode", 32'(bus16_mode), 32'(b >= 0));
        end
        cfg_width = 8'hFF;
        #1;
        chk(bus16_mode == 1'b1, "R8 bus mode all wide", 32'(bus16_mode), 32'd1);

        // R1..R7, R10, R11 sweep over all 16 area codes
        for (int c = 0; c < 16; c++) begin
            set_cfg(c);
            for (int s = 0; s < 2; s++) begin
                logic [2:0] ar;
                ar = 3'((c + s * 3) % 8);
                for (int m = 0; m < 8; m++) begin
                    run_access(ar, m[2], m[1], m[0], 20'(c * 1237 + s * 311 + m * 17),
                               16'(c * 4097 + m * 257) ^ 16'h5A3C, 1'b0);
                end
            end
        end

        // R9 request held during a busy access is ignored
        cfg_width  = 8'h04;
        cfg_states = 8'h04;
        cfg_waits  = 16'h0030;
        run_access(3'd2, 1'b0, 1'b0, 1'b0, 20'h12345, 16'h0000, 1'b1);
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            chk(!ext_rd && !ext_wr_hi && !ext_wr_lo && req_ready, "R9 no extra access",
                32'({ext_rd, ext_wr_hi, ext_wr_lo, req_ready}), 32'b0001);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule